// File: doc/BRIEF.md
# Sequenced Clock Source Select Register

This block is a memory-mapped control register that picks one of three clock sources for a storage-card host clock. The select field is two bits wide. Code 01 chooses the 533 MHz source, code 10 the 400 MHz source, and code 11 the 266 MHz source. The block also runs the hardware side of a source change. When a write is accepted it updates the requested code, raises a busy status for a fixed settle time, and then hands the new code to the active-source outputs.

Software writes the control register with a write-enable mask in the upper half-word next to the field it wants to change. Writes that are not allowed are refused, and the refusal sets a sticky error flag:

- writing code 00;
- moving directly between the 533 MHz and 400 MHz codes.

Software must reach either fast setting from the other by way of the 266 MHz code. Busy status and the error flag live in a separate status register. The field position, width and register offset of the status register are parameters.

Top module: `clksel_seq_reg`

## Requirements
- R1: After a synchronous active-low reset, both the requested code and the active code are 11 (266 MHz). Busy is low and the error flag is clear.
- R2: A control write changes only the select bits whose write-enable bits are set. Select bit i sits at position SEL_SHIFT+i and its enable at SEL_SHIFT+16+i. A bit with its enable clear keeps its old value.
- R3: A write whose merged select value is 00 leaves the requested and active codes unchanged, leaves busy low, and sets the error flag.
- R4: A write whose merged value moves from 01 to 10, or from 10 to 01, leaves the codes unchanged and busy low, and sets the error flag.
- R5: An accepted change updates the requested code at the write edge and holds busy high for exactly SETTLE_CYCLES cycles. The active code takes the new value in the same cycle that busy falls.
- R6: Any control write that arrives while busy is high is ignored. This includes a write in the final busy cycle. An ignored write does not change the requested code and does not set the error flag.
- R7: A write whose merged value equals the current code is accepted without raising busy or the error flag. This includes a write with no enable bits set.
- R8: A read of the control register returns the requested code at bits SEL_SHIFT+1..SEL_SHIFT. Every other bit reads zero, including the whole write-enable half.
- R9: A read of the status register returns STAT_WIDTH ones at STAT_SHIFT while busy, and zeros otherwise. The error flag reads at bit ERR_BIT. The flag stays set until a status-register write with bit ERR_BIT set clears it. A status write with that bit clear has no effect on the flag.
- R10: The three-bit source enable output is one-hot for the active code: bit 0 for 01, bit 1 for 10, bit 2 for 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe |
| reg_wr_addr | input | ADDR_W | Word address of the write |
| reg_wr_data | input | REG_W | Write data, enables in the upper half-word |
| reg_rd_addr | input | ADDR_W | Word address of the read |
| reg_rd_data | output | REG_W | Combinational read data |
| src_req | output | 2 | Requested source code |
| src_active | output | 2 | Source code currently in effect |
| src_enable | output | 3 | One-hot enable of the active source |
| switch_busy | output | 1 | Source change in progress |
| sel_error | output | 1 | Sticky illegal-write flag |

## Verification
The hardest states to reach from the ports are starting from the 400 MHz code and a write landing in the last busy cycle. Reaching the 400 MHz code takes an earlier accepted change followed by a full settle.

The bench resets before each case and makes that preparatory switch first. It then sweeps every start code against all four data codes and all four enable masks, and derives the merged value and the outcome arithmetically. A separate sequence counts the busy cycles down and writes exactly on the final one, then writes again on the first idle cycle.

// File: rtl/clksel_pkg.sv
// Package: source codes and small helper functions shared by the
// clock select register and its checker. Assumes a 2-bit select code.
package clksel_pkg;

    localparam logic [1:0] CODE_OFF  = 2'b00;
    localparam logic [1:0] CODE_F533 = 2'b01;
    localparam logic [1:0] CODE_F400 = 2'b10;
    localparam logic [1:0] CODE_F266 = 2'b11;

    // True when a move would jump directly between the two fast sources.
    function automatic logic is_fast_pair(input logic [1:0] from_c, input logic [1:0] to_c);
        return ((from_c == CODE_F533) && (to_c == CODE_F400)) ||
               ((from_c == CODE_F400) && (to_c == CODE_F533));
    endfunction

    // One-hot source enable for a code; zero for the prohibited code.
    function automatic logic [2:0] code_to_enable(input logic [1:0] c);
        logic [2:0] e;
        case (c)
            CODE_F533: e = 3'b001;
            CODE_F400: e = 3'b010;
            CODE_F266: e = 3'b100;
            default:   e = 3'b000;
        endcase
        return e;
    endfunction

endpackage

// File: rtl/clksel_wr_filter.sv
// Write filter: merges the written select bits under their enable mask
// and decides whether the result is accepted, rejected or a no-op.
// Assumes the current code is never 00 (guaranteed by the top).
module clksel_wr_filter
    import clksel_pkg::*;
(
    input  logic       ctrl_wr,
    input  logic       busy,
    input  logic [1:0] cur_sel,
    input  logic [1:0] wr_field,
    input  logic [1:0] wr_mask,
    output logic       accept,
    output logic       reject,
    output logic [1:0] next_sel
);

    logic [1:0] merged;

    // Per-bit merge of written bits over the held code.
    assign merged = (cur_sel & ~wr_mask) | (wr_field & wr_mask);

    // Classify the write; busy or unchanged writes produce no action.
    always_comb begin
        accept   = 1'b0;
        reject   = 1'b0;
        next_sel = merged;
        if (ctrl_wr && !busy && (merged != cur_sel)) begin
            if ((merged == CODE_OFF) || is_fast_pair(cur_sel, merged)) begin
                reject = 1'b1;
            end else begin
                accept = 1'b1;
            end
        end
    end

endmodule

// File: rtl/clksel_settle_timer.sv
// Settle timer: models the source switch latency. A load holds busy
// high for SETTLE_CYCLES cycles; done pulses in the last busy cycle.
// Assumes SETTLE_CYCLES >= 1.
module clksel_settle_timer #(
    parameter int SETTLE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic done
);

    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SETTLE_CYCLES);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter loaded on an accepted change, stopping at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == LAST_VAL);

endmodule

// File: rtl/clksel_readback.sv
// Read mux: presents the control register (select field only) and the
// status register (busy field and error flag). Unmapped addresses read 0.
// Assumes CTRL_ADDR != STAT_ADDR and all fields fit in REG_W.
module clksel_readback #(
    parameter int ADDR_W     = 4,
    parameter int REG_W      = 32,
    parameter int CTRL_ADDR  = 0,
    parameter int STAT_ADDR  = 1,
    parameter int SEL_SHIFT  = 0,
    parameter int STAT_SHIFT = 0,
    parameter int STAT_WIDTH = 1,
    parameter int ERR_BIT    = 8
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [1:0]        sel,
    input  logic              busy,
    input  logic              err,
    output logic [REG_W-1:0]  rd_data
);

    // Address decode and field placement for reads.
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(CTRL_ADDR)) begin
            rd_data[SEL_SHIFT +: 2] = sel;
        end else if (rd_addr == ADDR_W'(STAT_ADDR)) begin
            rd_data[STAT_SHIFT +: STAT_WIDTH] = {STAT_WIDTH{busy}};
            rd_data[ERR_BIT] = err;
        end
    end

endmodule

// File: rtl/clksel_seq_reg.sv
// Top: sequenced clock source select register. Holds the requested
// code, refuses illegal writes, runs the settle timer and then moves
// the active code. Synchronous active-low reset to the 266 MHz code.
// Assumes the select field plus its enables fit in the word.
module clksel_seq_reg
    import clksel_pkg::*;
#(
    parameter int ADDR_W        = 4,
    parameter int REG_W         = 32,
    parameter int CTRL_ADDR     = 0,
    parameter int STAT_ADDR     = 1,
    parameter int SEL_SHIFT     = 0,
    parameter int STAT_SHIFT    = 0,
    parameter int STAT_WIDTH    = 1,
    parameter int ERR_BIT       = 8,
    parameter int SETTLE_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [REG_W-1:0]  reg_wr_data,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [REG_W-1:0]  reg_rd_data,
    output logic [1:0]        src_req,
    output logic [1:0]        src_active,
    output logic [2:0]        src_enable,
    output logic              switch_busy,
    output logic              sel_error
);

    localparam int HALF_W = REG_W / 2;
    localparam int WE_POS = SEL_SHIFT + HALF_W;

    logic       ctrl_wr, stat_wr;
    logic       accept, reject, done, busy;
    logic [1:0] next_sel;
    logic [1:0] sel_q, active_q;
    logic       err_q;
    logic       unused_wr_bits;

    assign ctrl_wr        = reg_wr_en && (reg_wr_addr == ADDR_W'(CTRL_ADDR));
    assign stat_wr        = reg_wr_en && (reg_wr_addr == ADDR_W'(STAT_ADDR));
    assign unused_wr_bits = ^reg_wr_data;

    clksel_wr_filter u_filter (
        .ctrl_wr  (ctrl_wr),
        .busy     (busy),
        .cur_sel  (sel_q),
        .wr_field (reg_wr_data[SEL_SHIFT +: 2]),
        .wr_mask  (reg_wr_data[WE_POS +: 2]),
        .accept   (accept),
        .reject   (reject),
        .next_sel (next_sel)
    );

    clksel_settle_timer #(
        .SETTLE_CYCLES (SETTLE_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .busy  (busy),
        .done  (done)
    );

    // Requested code: updated only by an accepted change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= CODE_F266;
        end else if (accept) begin
            sel_q <= next_sel;
        end
    end

    // Active code: takes the requested code when the settle time ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= CODE_F266;
        end else if (done) begin
            active_q <= sel_q;
        end
    end

    // Sticky error: set by a rejected write, cleared by write-one to status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (reject) begin
            err_q <= 1'b1;
        end else if (stat_wr && reg_wr_data[ERR_BIT]) begin
            err_q <= 1'b0;
        end
    end

    clksel_readback #(
        .ADDR_W     (ADDR_W),
        .REG_W      (REG_W),
        .CTRL_ADDR  (CTRL_ADDR),
        .STAT_ADDR  (STAT_ADDR),
        .SEL_SHIFT  (SEL_SHIFT),
        .STAT_SHIFT (STAT_SHIFT),
        .STAT_WIDTH (STAT_WIDTH),
        .ERR_BIT    (ERR_BIT)
    ) u_rd (
        .rd_addr (reg_rd_addr),
        .sel     (sel_q),
        .busy    (busy),
        .err     (err_q),
        .rd_data (reg_rd_data)
    );

    assign src_req     = sel_q;
    assign src_active  = active_q;
    assign src_enable  = code_to_enable(active_q);
    assign switch_busy = busy;
    assign sel_error   = err_q;

endmodule

// File: rtl/clksel_seq_reg_chk.sv
// Checker: temporal properties of the clock select register, observed
// at its ports. Attached to every instance of the top by bind.
module clksel_seq_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr_en,
    input logic [1:0] src_req,
    input logic [1:0] src_active,
    input logic [2:0] src_enable,
    input logic       switch_busy,
    input logic       sel_error
);

    assert_no_zero_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (src_req != 2'b00) && (src_active != 2'b00));

    assert_no_up_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_req) == 2'b01) |-> (src_req != 2'b10));

    assert_no_down_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(src_req) == 2'b10) |-> (src_req != 2'b01));

    assert_busy_from_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(switch_busy) |-> $past(reg_wr_en));

    assert_active_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(src_active) |-> $fell(switch_busy));

    assert_idle_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !switch_busy |-> (src_active == src_req));

    assert_frozen_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(switch_busy) |-> $stable(src_req));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sel_error) && !$past(reg_wr_en)) |-> sel_error);

    assert_onehot_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(src_enable) == 1);

endmodule

bind clksel_seq_reg clksel_seq_reg_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_en   (reg_wr_en),
    .src_req     (src_req),
    .src_active  (src_active),
    .src_enable  (src_enable),
    .switch_busy (switch_busy),
    .sel_error   (sel_error)
);

// File: tb/clksel_seq_reg_test.sv
// Bench: sweeps every start code against every data code and enable
// mask, then covers busy timing, status reads and error clearing.
module clksel_seq_reg_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 4;
    localparam int REG_W      = 32;
    localparam int CTRL_A     = 0;
    localparam int STAT_A     = 1;
    localparam int SEL_SH     = 4;
    localparam int STAT_SH    = 0;
    localparam int STAT_W     = 2;
    localparam int ERR_B      = 8;
    localparam int SETTLE     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr_en = 1'b0;
    logic [ADDR_W-1:0] reg_wr_addr = '0;
    logic [REG_W-1:0]  reg_wr_data = '0;
    logic [ADDR_W-1:0] reg_rd_addr = '0;
    logic [REG_W-1:0]  reg_rd_data;
    logic [1:0]        src_req, src_active;
    logic [2:0]        src_enable;
    logic              switch_busy, sel_error;

    int checks = 0;
    int failures = 0;

    clksel_seq_reg #(
        .ADDR_W(ADDR_W), .REG_W(REG_W), .CTRL_ADDR(CTRL_A), .STAT_ADDR(STAT_A),
        .SEL_SHIFT(SEL_SH), .STAT_SHIFT(STAT_SH), .STAT_WIDTH(STAT_W),
        .ERR_BIT(ERR_B), .SETTLE_CYCLES(SETTLE)
    ) uut (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
        .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .src_req(src_req), .src_active(src_active), .src_enable(src_enable),
        .switch_busy(switch_busy), .sel_error(sel_error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; drives one write for the next rising edge.
    task automatic do_write(input int addr, input logic [31:0] data);
        reg_wr_en   = 1'b1;
        reg_wr_addr = ADDR_W'(addr);
        reg_wr_data = data;
        @(negedge clk);
        reg_wr_en   = 1'b0;
        reg_wr_data = '0;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [1:0] mask, input logic [1:0] code);
        return (32'(mask) << (SEL_SH + 16)) | (32'(code) << SEL_SH);
    endfunction

    function automatic logic [2:0] exp_en(input logic [1:0] code);
        return 3'b001 << (code - 2'd1);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (switch_busy && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        logic [1:0] merged;
        logic acc, rej;

        // R1 and R8: reset state and control readback
        do_reset();
        check("R1", {30'd0, src_req}, 32'd3);
        check("R1", {30'd0, src_active}, 32'd3);
        check("R1", {31'd0, switch_busy}, 32'd0);
        check("R1", {31'd0, sel_error}, 32'd0);
        reg_rd_addr = ADDR_W'(CTRL_A);
        #1;
        check("R8", reg_rd_data, 32'd3 << SEL_SH);

        // R2..R7, R10: sweep of start code x data code x enable mask
        for (int s = 1; s <= 3; s++) begin
            for (int d = 0; d <= 3; d++) begin
                for (int m = 0; m <= 3; m++) begin
                    do_reset();
                    if (s != 3) begin
                        do_write(CTRL_A, ctrl_word(2'b11, 2'(s)));
                        count_busy(n);
                    end
                    merged = (2'(s) & ~2'(m)) | (2'(d) & 2'(m));
                    acc = 1'b0;
                    rej = 1'b0;
                    if (merged != 2'(s)) begin
                        if (merged == 2'b00 || (s == 1 && merged == 2'b10) ||
                            (s == 2 && merged == 2'b01))
                            rej = 1'b1;
                        else
                            acc = 1'b1;
                    end
                    do_write(CTRL_A, ctrl_word(2'(m), 2'(d)));
                    check(rej ? (merged == 0 ? "R3" : "R4") : (acc ? "R2" : "R7"),
                          {30'd0, src_req}, {30'd0, acc ? merged : 2'(s)});
                    check("R7", {31'd0, switch_busy}, {31'd0, acc});
                    check("R3", {31'd0, sel_error}, {31'd0, rej});
                    check("R5", {30'd0, src_active}, 32'(s));
                    if (acc) begin
                        count_busy(n);
                        check("R5", n, SETTLE);
                        check("R5", {30'd0, src_active}, {30'd0, merged});
                        check("R10", {29'd0, src_enable}, {29'd0, exp_en(merged)});
                    end else begin
                        check("R10", {29'd0, src_enable}, {29'd0, exp_en(2'(s))});
                    end
                end
            end
        end

        // R6 and R9: status while busy, write in the last busy cycle
        do_reset();
        do_write(CTRL_A, ctrl_word(2'b11, 2'b01));
        reg_rd_addr = ADDR_W'(STAT_A);
        #1;
        check("R9", reg_rd_data, 32'h3);
        do_write(CTRL_A, ctrl_word(2'b11, 2'b00));
        check("R6", {31'd0, sel_error}, 32'd0);
        repeat (SETTLE - 2) @(negedge clk);
        check("R6", {31'd0, switch_busy}, 32'd1);
        do_write(CTRL_A, ctrl_word(2'b11, 2'b11));
        check("R6", {30'd0, src_req}, 32'd1);
        check("R6", {31'd0, switch_busy}, 32'd0);
        check("R5", {30'd0, src_active}, 32'd1);
        check("R6", {31'd0, sel_error}, 32'd0);
        do_write(CTRL_A, ctrl_word(2'b11, 2'b11));
        check("R5", {31'd0, switch_busy}, 32'd1);
        check("R5", {30'd0, src_req}, 32'd3);
        count_busy(n);

        // R9: error flag set, kept by a zero write, cleared by write-one
        do_write(CTRL_A, ctrl_word(2'b11, 2'b00));
        reg_rd_addr = ADDR_W'(STAT_A);
        #1;
        check("R9", reg_rd_data, 32'd1 << ERR_B);
        do_write(STAT_A, 32'h0);
        check("R9", {31'd0, sel_error}, 32'd1);
        do_write(STAT_A, 32'd1 << ERR_B);
        check("R9", {31'd0, sel_error}, 32'd0);
        #1;
        check("R9", reg_rd_data, 32'd0);
        reg_rd_addr = ADDR_W'(CTRL_A);
        #1;
        check("R8", reg_rd_data, 32'd3 << SEL_SH);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule